// File: doc/BRIEF.md
# Memory Upset Scrubber

This block keeps two groups of on-chip memory under continuous test while they are exposed to radiation. After `start` it writes a fixed fill word into every location of both groups. It then sweeps all words over and over. For each word it reads the stored value and compares all bits with the fill word. It counts how many bits have flipped and writes the fill word back over any word found in error, so each upset is counted once and then cleared.

The two groups differ in size: a large group and a small group, by default 1024 and 64 words of 18 bits. Each group has its own simple memory port with a read latency of one cycle. The block keeps four running totals: flipped bits and erroneous words for each group. It also keeps a count of completed sweeps. All totals saturate at their maximum value. The memory arrays themselves sit outside the block.

Top module: `sram_scrub_top`

## Requirements
- R1: While reset is held, and after reset until `start` is seen high, `test_mode` is low, every total reads zero, and no read or write strobe is raised on either memory port.
- R2: Once `start` is sampled high, the block writes the fill word to every address, one word per clock. It covers the large group first in rising address order, then the small group. The fill word is the 8-bit value 0x0F zero-extended to the word width (18'h0000F by default). `test_mode` goes high exactly LA_DEPTH+SB_DEPTH cycles after the clock edge that sampled `start`.
- R3: Once high, `test_mode` stays high until reset. A `start` pulse in test mode has no effect: it triggers no refill and no write.
- R4: Each sweep reads the large group from address 0 upward and then the small group from address 0 upward. A new read is issued every two cycles when no error is found. Read data is taken one cycle after the read strobe.
- R5: When a read word differs from the fill word, the owning group's bit total grows by the number of differing bit positions across the whole word, and its word total grows by one.
- R6: An erroneous word is rewritten with the fill word, at the same address, in the clock cycle right after its compare.
- R7: Errors found in the large group change only the large-group totals, and errors in the small group change only the small-group totals.
- R8: Each total saturates at 2^CNT_W-1 and holds there instead of wrapping.
- R9: `pass_count` grows by one each time a sweep of both groups finishes. A clean sweep takes exactly 2*(LA_DEPTH+SB_DEPTH) cycles.
- R10: A word that matches the fill word is never written in test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the fill when the block is idle |
| test_mode | output | 1 | High while sweeping |
| la_addr | output | $clog2(LA_DEPTH) | Large-group address |
| la_re | output | 1 | Large-group read strobe |
| la_we | output | 1 | Large-group write strobe |
| la_wdata | output | WORD_W | Large-group write data |
| la_rdata | input | WORD_W | Large-group read data, one cycle after `la_re` |
| sb_addr | output | $clog2(SB_DEPTH) | Small-group address |
| sb_re | output | 1 | Small-group read strobe |
| sb_we | output | 1 | Small-group write strobe |
| sb_wdata | output | WORD_W | Small-group write data |
| sb_rdata | input | WORD_W | Small-group read data, one cycle after the read strobe |
| la_bit_errs | output | CNT_W | Large-group flipped-bit total |
| la_word_errs | output | CNT_W | Large-group erroneous-word total |
| sb_bit_errs | output | CNT_W | Small-group flipped-bit total |
| sb_word_errs | output | CNT_W | Small-group erroneous-word total |
| pass_count | output | CNT_W | Completed sweeps |

## Verification
Some rules are checked by assertions on every cycle:
- A write to the same address follows every failed compare.
- A clean compare is never followed by a write.
- Reads and writes never collide.
- `test_mode` never drops.
- Totals never decrease and stay stuck once they reach their maximum.

Other behaviour only the bench scenarios can show:
- The exact bit counts for chosen flip masks, and which group gets them.
- The fill contents and when the fill ends.
- The read order inside a sweep.
- The length of a clean sweep.
- That a stray `start` does nothing.
- Saturation reached through real all-bit upsets.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_READ,
    ST_CMP,
    ST_WB
  } scrub_state_t;
endpackage

// File: rtl/scrub_popcount.sv
module scrub_popcount #(
  parameter int W = 18,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/scrub_sat_acc.sv
module scrub_sat_acc #(
  parameter int CNT_W = 32,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    cnt_d = sum[CNT_W] ? TOP : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R8: a total never moves backwards
  assert_no_decrease_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt_q >= $past(cnt_q)));
  // R8: once at the top value it stays there
  assert_hold_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP) |=> (cnt_q == TOP));
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq import scrub_pkg::*; #(
  parameter int DA = 1024,
  parameter int DB = 64,
  localparam int TOTAL = DA + DB,
  localparam int IW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mismatch,
  output logic          test_mode,
  output logic          rd_en,
  output logic          wr_en,
  output logic          cmp_valid,
  output logic          in_b,
  output logic          pass_done,
  output logic [IW-1:0] idx
);
  scrub_state_t state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic          last;
  logic [IW-1:0] idx_adv;

  assign last    = (idx_q == IW'(TOTAL - 1));
  assign idx_adv = last ? '0 : idx_q + 1'b1;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_FILL;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
      ST_FILL: begin
        idx_d  = idx_adv;
        idx_en = 1'b1;
        if (last) state_d = ST_READ;
      end
      ST_READ: state_d = ST_CMP;
      ST_CMP: if (mismatch) begin
        state_d = ST_WB;
      end else begin
        state_d = ST_READ;
        idx_d   = idx_adv;
        idx_en  = 1'b1;
      end
      ST_WB: begin
        state_d = ST_READ;
        idx_d   = idx_adv;
        idx_en  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign test_mode = (state_q == ST_READ) || (state_q == ST_CMP) || (state_q == ST_WB);
  assign rd_en     = (state_q == ST_READ);
  assign wr_en     = (state_q == ST_FILL) || (state_q == ST_WB);
  assign cmp_valid = (state_q == ST_CMP);
  assign in_b      = (idx_q >= IW'(DA));
  assign pass_done = last && (((state_q == ST_CMP) && !mismatch) || (state_q == ST_WB));
  assign idx       = idx_q;

  // R3: test mode is never left without reset
  assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> test_mode);
  // R4: a compare always follows a read
  assert_read_then_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> cmp_valid && $stable(idx_q));
endmodule

// File: rtl/sram_scrub_top.sv
module sram_scrub_top import scrub_pkg::*; #(
  parameter int         WORD_W    = 18,
  parameter logic [7:0] FILL_BYTE = 8'h0f,
  parameter int         LA_DEPTH  = 1024,
  parameter int         SB_DEPTH  = 64,
  parameter int         CNT_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        test_mode,
  output logic [$clog2(LA_DEPTH)-1:0] la_addr,
  output logic                        la_re,
  output logic                        la_we,
  output logic [WORD_W-1:0]           la_wdata,
  input  logic [WORD_W-1:0]           la_rdata,
  output logic [$clog2(SB_DEPTH)-1:0] sb_addr,
  output logic                        sb_re,
  output logic                        sb_we,
  output logic [WORD_W-1:0]           sb_wdata,
  input  logic [WORD_W-1:0]           sb_rdata,
  output logic [CNT_W-1:0]            la_bit_errs,
  output logic [CNT_W-1:0]            la_word_errs,
  output logic [CNT_W-1:0]            sb_bit_errs,
  output logic [CNT_W-1:0]            sb_word_errs,
  output logic [CNT_W-1:0]            pass_count
);
  localparam int TOTAL = LA_DEPTH + SB_DEPTH;
  localparam int IW    = $clog2(TOTAL);
  localparam int LA_AW = $clog2(LA_DEPTH);
  localparam int SB_AW = $clog2(SB_DEPTH);
  localparam int PC_W  = $clog2(WORD_W + 1);
  localparam logic [WORD_W-1:0] PATTERN = WORD_W'(FILL_BYTE);

  logic          rd_en, wr_en, cmp_valid, in_b, pass_done, mismatch;
  logic [IW-1:0] idx;
  logic [WORD_W-1:0] rd_word, diff;
  logic [PC_W-1:0]   flips;

  scrub_seq #(.DA(LA_DEPTH), .DB(SB_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mismatch(mismatch),
    .test_mode(test_mode), .rd_en(rd_en), .wr_en(wr_en),
    .cmp_valid(cmp_valid), .in_b(in_b), .pass_done(pass_done), .idx(idx)
  );

  assign la_addr  = idx[LA_AW-1:0];
  assign sb_addr  = SB_AW'(idx - IW'(LA_DEPTH));
  assign la_re    = rd_en & ~in_b;
  assign sb_re    = rd_en &  in_b;
  assign la_we    = wr_en & ~in_b;
  assign sb_we    = wr_en &  in_b;
  assign la_wdata = PATTERN;
  assign sb_wdata = PATTERN;

  assign rd_word  = in_b ? sb_rdata : la_rdata;
  assign diff     = rd_word ^ PATTERN;
  assign mismatch = cmp_valid && (diff != '0);

  scrub_popcount #(.W(WORD_W)) u_pop (.vec(diff), .count(flips));

  logic [3:0] grp_en;
  assign grp_en[0] = mismatch & ~in_b;
  assign grp_en[1] = mismatch & ~in_b;
  assign grp_en[2] = mismatch &  in_b;
  assign grp_en[3] = mismatch &  in_b;

  logic [CNT_W-1:0] totals [4];

  for (genvar g = 0; g < 4; g++) begin : g_tot
    scrub_sat_acc #(.CNT_W(CNT_W), .INC_W(PC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(grp_en[g]),
      .inc((g % 2 == 0) ? flips : PC_W'(1)),
      .count(totals[g])
    );
  end

  scrub_sat_acc #(.CNT_W(CNT_W), .INC_W(1)) u_pass (
    .clk(clk), .rst_n(rst_n), .en(pass_done), .inc(1'b1), .count(pass_count)
  );

  assign la_bit_errs  = totals[0];
  assign la_word_errs = totals[1];
  assign sb_bit_errs  = totals[2];
  assign sb_word_errs = totals[3];

  // R6: write-back to the same word right after a failed compare
  assert_wb_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> ($past(in_b) ? (sb_we && sb_addr == $past(sb_addr))
                              : (la_we && la_addr == $past(la_addr))));
  // R10: a clean compare is not followed by a write
  assert_clean_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !mismatch) |=> !(la_we || sb_we));
  // R4: a port never reads and writes in one cycle, one group at a time
  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({la_re, la_we, sb_re, sb_we}));
  // R1: nothing touches memory outside fill and test mode
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !$past(start) && !la_we && !sb_we) |=> !(la_re || sb_re) || test_mode);
endmodule

// File: tb/sim_sram_scrub_top.sv
module sim_sram_scrub_top;
  localparam int DA    = 16;
  localparam int DB    = 4;
  localparam int TOTAL = DA + DB;
  localparam int CW    = 6;
  localparam int TOPV  = (1 << CW) - 1;
  localparam logic [17:0] PAT = 18'h0000f;

  logic clk = 1'b0;
  logic rst_n, start, test_mode;
  logic [3:0] la_addr;
  logic [1:0] sb_addr;
  logic la_re, la_we, sb_re, sb_we;
  logic [17:0] la_wdata, sb_wdata, la_rdata, sb_rdata;
  logic [CW-1:0] la_bit_errs, la_word_errs, sb_bit_errs, sb_word_errs, pass_count;

  always #10 clk = ~clk;

  sram_scrub_top #(.LA_DEPTH(DA), .SB_DEPTH(DB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .test_mode(test_mode),
    .la_addr(la_addr), .la_re(la_re), .la_we(la_we), .la_wdata(la_wdata), .la_rdata(la_rdata),
    .sb_addr(sb_addr), .sb_re(sb_re), .sb_we(sb_we), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata),
    .la_bit_errs(la_bit_errs), .la_word_errs(la_word_errs),
    .sb_bit_errs(sb_bit_errs), .sb_word_errs(sb_word_errs), .pass_count(pass_count)
  );

  logic [17:0] mem_a [DA];
  logic [17:0] mem_b [DB];
  int wr_count = 0;

  always @(posedge clk) begin
    if (la_we) mem_a[la_addr] <= la_wdata;
    if (la_re) la_rdata <= mem_a[la_addr];
    if (sb_we) mem_b[sb_addr] <= sb_wdata;
    if (sb_re) sb_rdata <= mem_b[sb_addr];
    if (la_we || sb_we) wr_count <= wr_count + 1;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { bit grp; int addr; logic [17:0] mask; } upset_t;
  upset_t sbq[$];
  bit busy = 1'b0;
  int exp_ba = 0, exp_wa = 0, exp_bb = 0, exp_wb = 0;

  function automatic int sat(input int v);
    return (v > TOPV) ? TOPV : v;
  endfunction

  // monitor: pops an expected upset whenever a total moves
  initial begin
    int pba = 0, pwa = 0, pbb = 0, pwb = 0;
    forever begin
      @(negedge clk);
      if (rst_n && (la_bit_errs != CW'(pba) || la_word_errs != CW'(pwa) ||
                    sb_bit_errs != CW'(pbb) || sb_word_errs != CW'(pwb))) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "unexpected total change", int'(la_word_errs) + int'(sb_word_errs), pwa + pwb);
        end else begin
          upset_t it;
          busy = 1'b1;
          it = sbq.pop_front();
          if (!it.grp) begin
            exp_ba = sat(exp_ba + $countones(it.mask));
            exp_wa = sat(exp_wa + 1);
          end else begin
            exp_bb = sat(exp_bb + $countones(it.mask));
            exp_wb = sat(exp_wb + 1);
          end
          check(int'(la_bit_errs) == exp_ba, "R5", "large bit total", int'(la_bit_errs), exp_ba);
          check(int'(la_word_errs) == exp_wa, "R7", "large word total", int'(la_word_errs), exp_wa);
          check(int'(sb_bit_errs) == exp_bb, "R8", "small bit total", int'(sb_bit_errs), exp_bb);
          check(int'(sb_word_errs) == exp_wb, "R7", "small word total", int'(sb_word_errs), exp_wb);
          if (!it.grp)
            check(la_we && int'(la_addr) == it.addr, "R6", "write-back strobe/addr", int'(la_addr), it.addr);
          else
            check(sb_we && int'(sb_addr) == it.addr, "R6", "write-back strobe/addr", int'(sb_addr), it.addr);
        end
        pba = int'(la_bit_errs); pwa = int'(la_word_errs);
        pbb = int'(sb_bit_errs); pwb = int'(sb_word_errs);
        if (busy) begin
          @(negedge clk);
          check(sbq.size() == 0 && ((sbq.size() == 0) ? 1'b1 : 1'b0), "R6", "queue drained", sbq.size(), 0);
          busy = 1'b0;
        end
      end
    end
  end

  // driver: flip bits in a stored word, queue the expected upset, wait for it
  task automatic inject(input bit grp, input int addr, input logic [17:0] mask);
    upset_t it;
    @(negedge clk);
    it.grp = grp; it.addr = addr; it.mask = mask;
    sbq.push_back(it);
    if (!grp) mem_a[addr] = mem_a[addr] ^ mask;
    else      mem_b[addr] = mem_b[addr] ^ mask;
    do @(posedge clk); while (sbq.size() != 0 || busy);
    @(negedge clk);
    if (!grp) check(mem_a[addr] == PAT, "R6", "word restored", int'(mem_a[addr]), int'(PAT));
    else      check(mem_b[addr] == PAT, "R6", "word restored", int'(mem_b[addr]), int'(PAT));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 100000, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    int w0;
    bit ok;
    int p0;
    rst_n = 1'b0;
    start = 1'b0;
    for (int i = 0; i < DA; i++) mem_a[i] = 18'h3ffff;
    for (int i = 0; i < DB; i++) mem_b[i] = 18'h3ffff;
    repeat (3) @(negedge clk);
    check(!test_mode && !la_re && !la_we && !sb_re && !sb_we, "R1", "quiet in reset", int'(test_mode), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!test_mode, "R1", "test_mode low before start", int'(test_mode), 0);
    check(la_bit_errs == 0 && la_word_errs == 0 && sb_bit_errs == 0 && sb_word_errs == 0 && pass_count == 0,
          "R1", "totals zero", int'(la_bit_errs) + int'(sb_bit_errs) + int'(pass_count), 0);
    check(wr_count == 0 && mem_a[0] == 18'h3ffff, "R1", "no writes before start", wr_count, 0);

    // R2: fill and entry into test mode
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!test_mode && n < 1000) begin @(negedge clk); n++; end
    check(n == TOTAL + 1, "R2", "cycles to test mode", n, TOTAL + 1);
    check(wr_count == TOTAL, "R2", "fill write count", wr_count, TOTAL);
    ok = 1'b1;
    for (int i = 0; i < DA; i++) if (mem_a[i] != PAT) ok = 1'b0;
    for (int i = 0; i < DB; i++) if (mem_b[i] != PAT) ok = 1'b0;
    check(ok, "R2", "all words hold fill word", int'(ok), 1);

    // R4: sweep order, one read every two cycles
    n = 0;
    while (!(la_re && la_addr == 4'd0) && n < 1000) begin @(negedge clk); n++; end
    ok = 1'b1;
    for (int i = 0; i < TOTAL; i++) begin
      if (i < DA) begin if (!(la_re && int'(la_addr) == i)) ok = 1'b0; end
      else        begin if (!(sb_re && int'(sb_addr) == i - DA)) ok = 1'b0; end
      repeat (2) @(negedge clk);
    end
    check(ok, "R4", "read order large then small", int'(ok), 1);

    // R9: clean sweep length
    p0 = int'(pass_count);
    while (int'(pass_count) == p0) @(negedge clk);
    p0 = int'(pass_count);
    n = 0;
    while (int'(pass_count) == p0 && n < 1000) begin @(negedge clk); n++; end
    check(n == 2 * TOTAL, "R9", "clean sweep cycles", n, 2 * TOTAL);
    check(int'(pass_count) == p0 + 1, "R9", "pass step", int'(pass_count), p0 + 1);

    // R3 and R10: stray start, then a clean sweep writes nothing
    w0 = wr_count;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * TOTAL + 4) @(negedge clk);
    check(test_mode, "R3", "test mode held after start pulse", int'(test_mode), 1);
    check(wr_count == w0, "R10", "no writes on clean words", wr_count - w0, 0);

    // R5/R7: upsets in each group
    inject(1'b0, 3, 18'h00001);
    inject(1'b0, 15, 18'h00030);
    inject(1'b1, 2, 18'h0000f);
    inject(1'b1, 0, 18'h20000);
    // R8: all-bit upsets drive the large bit total into saturation
    inject(1'b0, 7, 18'h3ffff);
    inject(1'b0, 0, 18'h3ffff);
    inject(1'b0, 9, 18'h3ffff);
    inject(1'b0, 12, 18'h3ffff);
    check(int'(la_bit_errs) == TOPV, "R8", "large bit total saturated", int'(la_bit_errs), TOPV);
    check(int'(sb_bit_errs) == 5 && int'(sb_word_errs) == 2, "R7", "small totals unchanged by large upsets",
          int'(sb_bit_errs), 5);
    repeat (2 * TOTAL) @(negedge clk);
    check(int'(la_bit_errs) == TOPV, "R8", "saturated total holds", int'(la_bit_errs), TOPV);

    summary();
    $finish;
  end
endmodule